// File: doc/BRIEF.md
# Multi-Size Address Translation Cache

This block is a small, fully associative translation cache for a device-side memory management unit. Each slot maps one page of 16 MB, 1 MB, 64 KB or 4 KB, so one lookup compares the device address against every slot over a range set by that slot's own size code. A lookup presents a 32-bit device address. One clock later the block returns a hit flag, the translated physical address and the slot's access attributes: endianness, element size and mixed-size access.

Software maintains the slots through a replacement pointer held in a lock register. A write to the lock register points it at any slot. A load command writes the staged tag and data words into the pointed slot and advances the pointer, wrapping after the last slot. The pointed slot can always be read back, which lets software scan every slot by stepping the pointer. One command invalidates only the pointed slot, and another clears every slot at once. The cache holds no preserved region, so every slot is open to replacement. Reset empties the cache and returns the pointer to slot 0.

The tag word holds the device page address in bits 31:12, the valid flag in bit 2 and the size code in bits 1:0. The data word holds the physical page address in bits 31:12, endianness in bit 9, element size in bits 8:7 and mixed access in bit 6.

Top module: `xlat_cache`

## Requirements
- R1: After reset every slot is invalid, `lk_victim` is 0, `lu_vld` is 0 and `rb_tag` reads 0, so any lookup misses.
- R2: The size code in tag bits 1:0 selects the page: 0 = 1 MB, 1 = 64 KB, 2 = 4 KB, 3 = 16 MB. A slot matches when its valid bit is set and the device address lies in [base, base + size), where base is the tag address with its bits below the page size cleared.
- R3: On a hit `lu_pa` is the data word with its bits below the page size cleared, ORed with the device-address bits below the page size.
- R4: On a hit the attributes come from data bit 9 (`lu_endian`), bits 8:7 (`lu_elsz`) and bit 6 (`lu_mixed`). On a miss `lu_hit`, `lu_pa` and all attributes are 0.
- R5: When several valid slots match, the lowest-numbered slot supplies the result.
- R6: `lu_vld` is high exactly one clock after `lu_req`. The result reflects the slot contents in the cycle the request was taken.
- R7: `cmd_load` writes `stage_tag` and `stage_data` into the slot named by `lk_victim`. The slot's valid flag is taken from `stage_tag` bit 2. `lk_victim` then advances by one, and from N-1 it goes to 0.
- R8: `lk_wr` loads `lk_wr_victim` into `lk_victim`. A load in the same cycle takes precedence.
- R9: `rb_tag` and `rb_data` show the tag word, with its current valid flag in bit 2, and the data word of the slot named by `lk_victim`.
- R10: `cmd_zap` clears the valid flag of the slot named by `lk_victim` and no other, and leaves `lk_victim` unchanged.
- R11: `cmd_wipe` clears the valid flag of every slot and leaves `lk_victim` unchanged. It takes precedence over `cmd_zap`, which in turn takes precedence over `cmd_load`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| lk_wr | input | 1 | Write the replacement pointer |
| lk_wr_victim | input | $clog2(N) | New pointer value, below N |
| cmd_load | input | 1 | Write staged words into the pointed slot |
| stage_tag | input | 32 | Staged tag word |
| stage_data | input | 32 | Staged data word |
| cmd_zap | input | 1 | Invalidate the pointed slot |
| cmd_wipe | input | 1 | Invalidate all slots |
| lk_victim | output | $clog2(N) | Current replacement pointer |
| rb_tag | output | 32 | Tag word of the pointed slot, with its valid flag |
| rb_data | output | 32 | Data word of the pointed slot |
| lu_req | input | 1 | Lookup request |
| lu_addr | input | 32 | Device address to translate |
| lu_vld | output | 1 | Lookup result valid |
| lu_hit | output | 1 | Lookup hit |
| lu_pa | output | 32 | Translated physical address |
| lu_endian | output | 1 | Endianness attribute |
| lu_elsz | output | 2 | Element size attribute |
| lu_mixed | output | 1 | Mixed-size access attribute |

## Verification
The assertions assume that every value written through `lk_wr_victim` is below the slot count. The pointer checks after an invalidate apply only in cycles where no lock write arrives alongside it, because such a write moves the pointer in the same cycle. The stimulus holds each command or lock write for a single clock and follows it with an idle clock. It never issues a lookup in the same cycle as a command, so each expected result follows from the slot contents left by the commands before it. Pointer values are always written inside the slot range, and the wrap is reached by writing N-1 before a load.

// File: rtl/xlat_pkg.sv
`timescale 1ns/1ps
package xlat_pkg;
    localparam int AW     = 32;
    localparam int VBIT   = 2;
    localparam int END_B  = 9;
    localparam int ELSZ_H = 8;
    localparam int ELSZ_L = 7;
    localparam int MIX_B  = 6;

    typedef enum logic [1:0] {
        PG_1M  = 2'd0,
        PG_64K = 2'd1,
        PG_4K  = 2'd2,
        PG_16M = 2'd3
    } pgsz_e;

    // Mask of the in-page offset bits for a size code.
    function automatic logic [AW-1:0] off_mask(input logic [1:0] code);
        logic [AW-1:0] m;
        unique case (pgsz_e'(code))
            PG_1M:   m = 32'h000F_FFFF;
            PG_64K:  m = 32'h0000_FFFF;
            PG_4K:   m = 32'h0000_0FFF;
            default: m = 32'h00FF_FFFF;
        endcase
        return m;
    endfunction
endpackage

// File: rtl/xlat_slot.sv
`timescale 1ns/1ps
module xlat_slot
    import xlat_pkg::*;
#(
    parameter int IDXW = 5,
    parameter int IDX  = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            zap_en,
    input  logic            wipe_en,
    input  logic [IDXW-1:0] victim,
    input  logic [AW-1:0]   stage_tag,
    input  logic [AW-1:0]   stage_data,
    input  logic [AW-1:0]   lu_addr,
    output logic            match,
    output logic [AW-1:0]   pa_out,
    output logic [AW-1:0]   tag_out,
    output logic [AW-1:0]   data_out
);
    localparam logic [IDXW-1:0] ME = IDXW'(IDX);

    logic          vld_q;
    logic [AW-1:0] tag_q;
    logic [AW-1:0] data_q;
    logic [AW-1:0] om;
    logic          picked;

    assign picked = (victim == ME);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            tag_q  <= '0;
            data_q <= '0;
        end else if (wipe_en) begin
            vld_q <= 1'b0;
        end else if (zap_en && picked) begin
            vld_q <= 1'b0;
        end else if (wr_en && picked) begin
            vld_q  <= stage_tag[VBIT];
            tag_q  <= stage_tag;
            data_q <= stage_data;
        end
    end

    always_comb begin
        om       = off_mask(tag_q[1:0]);
        match    = vld_q && ((lu_addr & ~om) == (tag_q & ~om));
        pa_out   = (data_q & ~om) | (lu_addr & om);
        tag_out  = {tag_q[AW-1:VBIT+1], vld_q, tag_q[VBIT-1:0]};
        data_out = data_q;
    end
endmodule

// File: rtl/xlat_pick.sv
`timescale 1ns/1ps
module xlat_pick
    import xlat_pkg::*;
#(
    parameter int N = 32
) (
    input  logic [N-1:0]  match,
    input  logic [AW-1:0] pa_vec   [N],
    input  logic [AW-1:0] data_vec [N],
    output logic          any,
    output logic [AW-1:0] pa,
    output logic [AW-1:0] data
);
    // Scan from the top so the lowest-numbered match is written last.
    always_comb begin
        any  = |match;
        pa   = '0;
        data = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) begin
                pa   = pa_vec[i];
                data = data_vec[i];
            end
        end
    end
endmodule

// File: rtl/xlat_victim.sv
`timescale 1ns/1ps
module xlat_victim #(
    parameter int N    = 32,
    parameter int IDXW = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step,
    input  logic            lk_wr,
    input  logic [IDXW-1:0] lk_val,
    output logic [IDXW-1:0] victim
);
    localparam logic [IDXW-1:0] LAST = IDXW'(N - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            victim <= '0;
        end else if (step) begin
            victim <= (victim == LAST) ? '0 : victim + 1'b1;
        end else if (lk_wr) begin
            victim <= lk_val;
        end
    end
endmodule

// File: rtl/xlat_cache.sv
`timescale 1ns/1ps
module xlat_cache
    import xlat_pkg::*;
#(
    parameter  int N    = 32,
    localparam int IDXW = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lk_wr,
    input  logic [IDXW-1:0] lk_wr_victim,
    input  logic            cmd_load,
    input  logic [31:0]     stage_tag,
    input  logic [31:0]     stage_data,
    input  logic            cmd_zap,
    input  logic            cmd_wipe,
    output logic [IDXW-1:0] lk_victim,
    output logic [31:0]     rb_tag,
    output logic [31:0]     rb_data,
    input  logic            lu_req,
    input  logic [31:0]     lu_addr,
    output logic            lu_vld,
    output logic            lu_hit,
    output logic [31:0]     lu_pa,
    output logic            lu_endian,
    output logic [1:0]      lu_elsz,
    output logic            lu_mixed
);
    logic          wipe_eff, zap_eff, load_eff;
    logic [N-1:0]  match;
    logic [AW-1:0] slot_pa   [N];
    logic [AW-1:0] slot_tag  [N];
    logic [AW-1:0] slot_data [N];
    logic          any;
    logic [AW-1:0] sel_pa, sel_data;

    assign wipe_eff = cmd_wipe;
    assign zap_eff  = cmd_zap && !cmd_wipe;
    assign load_eff = cmd_load && !cmd_zap && !cmd_wipe;

    xlat_victim #(.N(N), .IDXW(IDXW)) vic_i (
        .clk(clk), .rst_n(rst_n), .step(load_eff),
        .lk_wr(lk_wr), .lk_val(lk_wr_victim), .victim(lk_victim)
    );

    for (genvar g = 0; g < N; g++) begin : g_slot
        xlat_slot #(.IDXW(IDXW), .IDX(g)) slot_i (
            .clk(clk), .rst_n(rst_n),
            .wr_en(load_eff), .zap_en(zap_eff), .wipe_en(wipe_eff),
            .victim(lk_victim), .stage_tag(stage_tag), .stage_data(stage_data),
            .lu_addr(lu_addr), .match(match[g]), .pa_out(slot_pa[g]),
            .tag_out(slot_tag[g]), .data_out(slot_data[g])
        );
    end

    xlat_pick #(.N(N)) pick_i (
        .match(match), .pa_vec(slot_pa), .data_vec(slot_data),
        .any(any), .pa(sel_pa), .data(sel_data)
    );

    assign rb_tag  = slot_tag[lk_victim];
    assign rb_data = slot_data[lk_victim];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lu_vld    <= 1'b0;
            lu_hit    <= 1'b0;
            lu_pa     <= '0;
            lu_endian <= 1'b0;
            lu_elsz   <= '0;
            lu_mixed  <= 1'b0;
        end else begin
            lu_vld <= lu_req;
            if (lu_req) begin
                lu_hit    <= any;
                lu_pa     <= any ? sel_pa : '0;
                lu_endian <= any && sel_data[END_B];
                lu_elsz   <= any ? sel_data[ELSZ_H:ELSZ_L] : 2'b00;
                lu_mixed  <= any && sel_data[MIX_B];
            end
        end
    end
endmodule

// File: rtl/xlat_cache_chk.sv
`timescale 1ns/1ps
module xlat_cache_chk #(
    parameter int N    = 32,
    parameter int IDXW = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            lk_wr,
    input logic            cmd_load,
    input logic            cmd_zap,
    input logic            cmd_wipe,
    input logic [IDXW-1:0] lk_victim,
    input logic [31:0]     rb_tag,
    input logic            lu_req,
    input logic            lu_vld,
    input logic            lu_hit,
    input logic [31:0]     lu_pa,
    input logic            lu_endian,
    input logic [1:0]      lu_elsz,
    input logic            lu_mixed
);
    localparam logic [IDXW-1:0] LAST = IDXW'(N - 1);

    assert_result_lat_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lu_req |=> lu_vld);

    assert_no_spurious_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !lu_req |=> !lu_vld);

    assert_miss_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lu_vld && !lu_hit) |-> (lu_pa == 32'h0 && !lu_endian && lu_elsz == 2'b00 && !lu_mixed));

    assert_ptr_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_load && !cmd_zap && !cmd_wipe && lk_victim == LAST) |=> (lk_victim == '0));

    assert_ptr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_load && !cmd_zap && !cmd_wipe && lk_victim != LAST)
        |=> (lk_victim == IDXW'($past(lk_victim) + 1'b1)));

    assert_zap_slot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_zap && !cmd_wipe && !lk_wr) |=> (!rb_tag[2] && $stable(lk_victim)));

    assert_wipe_all_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wipe && !lk_wr) |=> (!rb_tag[2] && $stable(lk_victim)));
endmodule

bind xlat_cache xlat_cache_chk #(.N(N), .IDXW(IDXW)) chk_i (
    .clk(clk), .rst_n(rst_n), .lk_wr(lk_wr), .cmd_load(cmd_load),
    .cmd_zap(cmd_zap), .cmd_wipe(cmd_wipe), .lk_victim(lk_victim),
    .rb_tag(rb_tag), .lu_req(lu_req), .lu_vld(lu_vld), .lu_hit(lu_hit),
    .lu_pa(lu_pa), .lu_endian(lu_endian), .lu_elsz(lu_elsz), .lu_mixed(lu_mixed)
);

// File: tb/xlat_cache_tb_top.sv
`timescale 1ns/1ps
module xlat_cache_tb_top;
    localparam int N    = 32;
    localparam int IDXW = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            lk_wr = 1'b0;
    logic [IDXW-1:0] lk_wr_victim = '0;
    logic            cmd_load = 1'b0;
    logic [31:0]     stage_tag = '0;
    logic [31:0]     stage_data = '0;
    logic            cmd_zap = 1'b0;
    logic            cmd_wipe = 1'b0;
    logic [IDXW-1:0] lk_victim;
    logic [31:0]     rb_tag, rb_data;
    logic            lu_req = 1'b0;
    logic [31:0]     lu_addr = '0;
    logic            lu_vld, lu_hit, lu_endian, lu_mixed;
    logic [31:0]     lu_pa;
    logic [1:0]      lu_elsz;

    always #4 clk = ~clk;

    xlat_cache #(.N(N)) dut_i (.*);

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [31:0] m_tag  [N];
    logic [31:0] m_data [N];
    int          m_vic = 0;

    logic [63:0] exp_q [$];
    string       req_q [$];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    // R2 size decode as stated in the requirement
    function automatic logic [31:0] offm(input logic [1:0] c);
        case (c)
            2'd0: return 32'h000F_FFFF;
            2'd1: return 32'h0000_FFFF;
            2'd2: return 32'h0000_0FFF;
            default: return 32'h00FF_FFFF;
        endcase
    endfunction

    function automatic logic [31:0] mk_tag(input logic [31:0] va, input bit v, input logic [1:0] sz);
        return (va & 32'hFFFF_F000) | {29'd0, v, sz};
    endfunction

    function automatic logic [31:0] mk_data(input logic [31:0] pa, input bit e,
                                           input logic [1:0] el, input bit m);
        return (pa & 32'hFFFF_F000) | ({31'd0, e} << 9) | ({30'd0, el} << 7) | ({31'd0, m} << 6);
    endfunction

    // Expected lookup packed as {hit, endian, elsz, mixed, pa}
    function automatic logic [63:0] expect_for(input logic [31:0] a);
        logic [31:0] om;
        for (int i = 0; i < N; i++) begin
            if (m_tag[i][2]) begin
                om = offm(m_tag[i][1:0]);
                if ((a & ~om) == (m_tag[i] & ~om))
                    return {27'd0, 1'b1, m_data[i][9], m_data[i][8:7], m_data[i][6],
                            (m_data[i] & ~om) | (a & om)};
            end
        end
        return 64'd0;
    endfunction

    task automatic look(input logic [31:0] a, input string req);
        exp_q.push_back(expect_for(a));
        req_q.push_back(req);
        @(negedge clk);
        lu_req  = 1'b1;
        lu_addr = a;
        @(negedge clk);
        lu_req  = 1'b0;
    endtask

    task automatic lk_set(input int v);
        @(negedge clk);
        lk_wr = 1'b1;
        lk_wr_victim = v[IDXW-1:0];
        m_vic = v;
        @(negedge clk);
        lk_wr = 1'b0;
    endtask

    task automatic load(input logic [31:0] t, input logic [31:0] d);
        @(negedge clk);
        cmd_load = 1'b1;
        stage_tag = t;
        stage_data = d;
        m_tag[m_vic] = t;
        m_data[m_vic] = d;
        m_vic = (m_vic + 1) % N;
        @(negedge clk);
        cmd_load = 1'b0;
    endtask

    task automatic zap();
        @(negedge clk);
        cmd_zap = 1'b1;
        m_tag[m_vic][2] = 1'b0;
        @(negedge clk);
        cmd_zap = 1'b0;
    endtask

    task automatic wipe();
        @(negedge clk);
        cmd_wipe = 1'b1;
        for (int i = 0; i < N; i++) m_tag[i][2] = 1'b0;
        @(negedge clk);
        cmd_wipe = 1'b0;
    endtask

    task automatic readback(input int v, input string req);
        lk_set(v);
        @(negedge clk);
        check(rb_tag == m_tag[v], req, "readback tag", {32'd0, rb_tag}, {32'd0, m_tag[v]});
        check(rb_data == m_data[v], req, "readback data", {32'd0, rb_data}, {32'd0, m_data[v]});
    endtask

    task automatic vic_is(input int v, input string req);
        @(negedge clk);
        check(lk_victim == v[IDXW-1:0], req, "victim pointer",
              {59'd0, lk_victim}, {59'd0, v[IDXW-1:0]});
    endtask

    // Monitor: pops expected lookups as results appear
    always @(negedge clk) begin
        if (rst_n && lu_vld) begin
            logic [63:0] act;
            act = {27'd0, lu_hit, lu_endian, lu_elsz, lu_mixed, lu_pa};
            if (exp_q.size() == 0) begin
                check(1'b0, "R6", "unexpected result", act, 64'd0);
            end else begin
                logic [63:0] e;
                string r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                check(act == e, r, "lookup", act, e);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_tag[i] = '0;
            m_data[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(lk_victim == '0, "R1", "victim after reset", {59'd0, lk_victim}, 64'd0);
        check(!lu_vld, "R1", "lu_vld after reset", {63'd0, lu_vld}, 64'd0);
        check(rb_tag == 32'd0, "R1", "slot empty after reset", {32'd0, rb_tag}, 64'd0);
        look(32'h0000_0000, "R1");

        // R7 fill slots 0..5 through the pointer
        load(mk_tag(32'h1234_5000, 1, 2'd3), mk_data(32'h8000_0000, 1, 2'd0, 0));
        load(mk_tag(32'h2030_0000, 1, 2'd0), mk_data(32'h9000_0000, 0, 2'd2, 0));
        load(mk_tag(32'h3001_0000, 1, 2'd1), mk_data(32'hA005_0000, 0, 2'd1, 1));
        load(mk_tag(32'h4000_5000, 1, 2'd2), mk_data(32'hB000_7000, 1, 2'd3, 1));
        load(mk_tag(32'h1234_6000, 1, 2'd2), mk_data(32'hC000_0000, 0, 2'd0, 1));
        load(mk_tag(32'h5000_0000, 0, 2'd0), mk_data(32'hE000_0000, 1, 2'd1, 0));
        vic_is(6, "R7");

        // R2 R3 R4 ranges of each size, edges inside and outside
        look(32'h1200_0000, "R2");
        look(32'h12FF_FFFF, "R3");
        look(32'h1300_0000, "R2");
        look(32'h11FF_FFFF, "R2");
        look(32'h2030_0000, "R4");
        look(32'h203F_FFFF, "R3");
        look(32'h2040_0000, "R2");
        look(32'h3001_0000, "R4");
        look(32'h3001_FFFF, "R3");
        look(32'h3002_0000, "R2");
        look(32'h4000_5000, "R4");
        look(32'h4000_5FFF, "R3");
        look(32'h4000_6000, "R2");
        look(32'h4000_4FFF, "R2");
        look(32'h5000_0010, "R7");
        // R5 overlap: slot 0 beats slot 4
        look(32'h1234_6ABC, "R5");

        // R9 read-back via the pointer, R8 pointer writes
        for (int s = 0; s < 6; s++) readback(s, "R9");
        vic_is(5, "R8");

        // R10 invalidate slot 0 only
        lk_set(0);
        zap();
        vic_is(0, "R10");
        @(negedge clk);
        check(!rb_tag[2], "R10", "zapped slot valid", {63'd0, rb_tag[2]}, 64'd0);
        look(32'h1234_6ABC, "R10");
        look(32'h1200_0000, "R10");
        look(32'h2030_1234, "R10");

        // R7 wrap from the last slot
        lk_set(N - 1);
        load(mk_tag(32'h6000_0000, 1, 2'd2), mk_data(32'hD000_0000, 1, 2'd2, 0));
        vic_is(0, "R7");
        look(32'h6000_0123, "R7");
        readback(N - 1, "R9");

        // R11 invalidate everything, pointer kept
        lk_set(7);
        wipe();
        vic_is(7, "R11");
        look(32'h6000_0123, "R11");
        look(32'h3001_0000, "R11");
        look(32'h1234_6ABC, "R11");
        readback(1, "R11");
        readback(N - 1, "R11");

        // Reuse after clearing
        lk_set(0);
        load(mk_tag(32'h7000_0000, 1, 2'd3), mk_data(32'hF100_0000, 0, 2'd3, 1));
        look(32'h70AB_CDEF, "R11");

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R6", "results outstanding",
              {32'd0, 32'(exp_q.size())}, 64'd0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule